// File: doc/BRIEF.md
# Keyed Window Watchdog

This block is a 16-bit watchdog for a safety-minded controller. A counter advances on a count-enable strobe from the watchdog time base. When the counter meets the programmed timeout, the block drives a chip reset pulse for a fixed number of bus clocks. Software keeps the system alive by writing a two-word refresh key to a key port. Both words must arrive within a short deadline counted in bus clocks.

Configuration, timeout and window registers can be written once after reset. Writing the configuration register closes all three. A separate two-word unlock key reopens them. An optional window turns a refresh that comes too early into a reset. An optional divide-by-256 prescaler stretches the time base. A byte compare mode matches only one byte of the counter against the timeout, so a test can reach the reset quickly.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset the reset output is low and the configuration is: watchdog enabled, window off, prescaler off, full 16-bit compare. The timeout is TOUT_INIT (default 0x0100), the window is 0, and the three registers are writable.
- R2: Writing 0x02A6 and then 0x80B4 to the key port (address 0), with the second write on the 1st to 16th bus clock after the first, clears the counter to zero and does not assert reset.
- R3: If the second refresh word comes 17 or more clocks after the first, the sequence is dropped without any effect. The late word is then ignored and the counter is not cleared.
- R4: If the word written to the key port right after 0x02A6 is anything other than 0x80B4, a reset pulse starts.
- R5: When the watchdog is enabled (config bit 0) and the counter matches the timeout, the counter clears and the reset output goes high for exactly RST_CYCLES (default 4) bus clocks.
- R6: With config bit 2 set, the counter advances once per 256 count-enable strobes instead of once per strobe.
- R7: With config bit 1 set, a correct refresh key pair completed while the counter is below the window register (address 3) starts a reset pulse and does not count as a refresh.
- R8: The configuration (address 1), timeout (address 2) and window (address 3) registers accept writes only while open. Open is the state after reset or after an unlock. A configuration write closes them, and any later write to them is ignored.
- R9: Writing 0x20C5 and then 0x28D9 to the key port within 16 clocks reopens the registers. A wrong second word or a late one drops the sequence without reopening the registers and without reset.
- R10: Config bits 4:3 select the compare: 01 matches only counter bits 7:0 against timeout bits 7:0, 10 matches only bits 15:8, and 00 or 11 match all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntTick | input | 1 | Count-enable strobe from the watchdog time base, one bus clock wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 key port, 1 configuration, 2 timeout, 3 window |
| wrData | input | 16 | Write data |
| wdgRst | output | 1 | Reset request pulse |

## Verification
The assertions assume at most one register write per clock. They assume the count-enable strobe is already synchronous to the bus clock and that reset is applied only from outside. The stimulus drives every input half a period away from the sampling edge. It holds the time-base strobe low while registers are set up, so the counter starts from a known value. Reset is asserted and released one time unit after a falling edge, so the comparison against the reference model never meets a half-applied reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int WORD_W = 16;
  localparam int CFG_W  = 5;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TOUT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 2'd3;

  localparam logic [WORD_W-1:0] KEY_REF_A = 16'h02A6;
  localparam logic [WORD_W-1:0] KEY_REF_B = 16'h80B4;
  localparam logic [WORD_W-1:0] KEY_UNL_A = 16'h20C5;
  localparam logic [WORD_W-1:0] KEY_UNL_B = 16'h28D9;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REF, SEQ_UNL} seq_state_t;

  typedef struct packed {
    logic refreshOk;
    logic refreshBad;
    logic cfgWe;
    logic toutWe;
    logic winWe;
  } wdg_strobe_t;
endpackage

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int KEY_DEADLINE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              earlyZone,
  output wdg_strobe_t       strb
);
  localparam int AGE_W = $clog2(KEY_DEADLINE + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(KEY_DEADLINE - 1);

  seq_state_t       seqQ;
  logic [AGE_W-1:0] ageQ;
  logic             cfgOpenQ;
  logic             keyWr;

  assign keyWr = wrEn && (wrAddr == ADDR_KEY);

  always_comb begin
    strb = '0;
    if (keyWr && seqQ == SEQ_REF) begin
      if (wrData == KEY_REF_B && !earlyZone) strb.refreshOk = 1'b1;
      else                                   strb.refreshBad = 1'b1;
    end
    strb.cfgWe  = wrEn && (wrAddr == ADDR_CFG)  && cfgOpenQ;
    strb.toutWe = wrEn && (wrAddr == ADDR_TOUT) && cfgOpenQ;
    strb.winWe  = wrEn && (wrAddr == ADDR_WIN)  && cfgOpenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ     <= SEQ_IDLE;
      ageQ     <= '0;
      cfgOpenQ <= 1'b1;
    end else begin
      if (strb.cfgWe) cfgOpenQ <= 1'b0;
      case (seqQ)
        SEQ_IDLE: begin
          if (keyWr && wrData == KEY_REF_A) begin
            seqQ <= SEQ_REF;
            ageQ <= '0;
          end else if (keyWr && wrData == KEY_UNL_A) begin
            seqQ <= SEQ_UNL;
            ageQ <= '0;
          end
        end
        default: begin
          if (keyWr) begin
            seqQ <= SEQ_IDLE;
            if (seqQ == SEQ_UNL && wrData == KEY_UNL_B) cfgOpenQ <= 1'b1;
          end else if (ageQ == AGE_LAST) begin
            seqQ <= SEQ_IDLE;
          end else begin
            ageQ <= ageQ + 1'b1;
          end
        end
      endcase
    end
  end

  AST_SEQ_DEADLINE: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ != SEQ_IDLE) |-> (ageQ < AGE_W'(KEY_DEADLINE))) else $error("deadline overrun"); // R3
  AST_CFG_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWe |=> !cfgOpenQ) else $error("config stayed open"); // R8
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && seqQ == SEQ_UNL && wrData == KEY_UNL_B) |=> cfgOpenQ) else $error("unlock lost"); // R9
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int              RST_CYCLES = 4,
  parameter int              PRE_LOG2   = 8,
  parameter logic [15:0]     TOUT_INIT  = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic [WORD_W-1:0] wrData,
  input  wdg_strobe_t       strb,
  output logic              earlyZone,
  output logic              rstOut
);
  localparam int PULSE_W = $clog2(RST_CYCLES + 1);
  localparam int LANES   = WORD_W / 8;
  localparam logic [PRE_LOG2-1:0] PRE_MAX = '1;
  localparam logic [CFG_W-1:0]    CFG_INIT = CFG_W'(1);

  logic [CFG_W-1:0]    cfgQ;
  logic [WORD_W-1:0]   toutQ, winQ, cntQ;
  logic [PRE_LOG2-1:0] preQ;
  logic [PULSE_W-1:0]  pulseQ;
  logic [LANES-1:0]    laneEq;
  logic                enBit, winBit, preBit, cmpHit, hit, fire, step;
  logic [1:0]          cmpSel;

  assign enBit  = cfgQ[0];
  assign winBit = cfgQ[1];
  assign preBit = cfgQ[2];
  assign cmpSel = cfgQ[4:3];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneEq[g] = (cntQ[g*8 +: 8] == toutQ[g*8 +: 8]);
  end

  always_comb begin
    case (cmpSel)
      2'b01:   cmpHit = laneEq[0];
      2'b10:   cmpHit = laneEq[LANES-1];
      default: cmpHit = &laneEq;
    endcase
  end

  assign hit       = enBit && cmpHit;
  assign fire      = hit || strb.refreshBad;
  assign step      = enBit && cntTick && (!preBit || preQ == PRE_MAX);
  assign earlyZone = winBit && (cntQ < winQ);
  assign rstOut    = (pulseQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= CFG_INIT;
      toutQ <= TOUT_INIT;
      winQ  <= '0;
    end else begin
      if (strb.cfgWe)  cfgQ  <= wrData[CFG_W-1:0];
      if (strb.toutWe) toutQ <= wrData;
      if (strb.winWe)  winQ  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      preQ <= '0;
    end else if (fire || strb.refreshOk) begin
      cntQ <= '0;
      preQ <= '0;
    end else begin
      if (enBit && cntTick && preBit) preQ <= preQ + 1'b1;
      if (step) cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseQ <= '0;
    else if (fire)           pulseQ <= PULSE_W'(RST_CYCLES);
    else if (pulseQ != '0)   pulseQ <= pulseQ - 1'b1;
  end

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.refreshOk |=> (cntQ == '0)) else $error("refresh did not clear"); // R2
  AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    strb.refreshBad |=> rstOut) else $error("bad refresh no reset"); // R4
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (rstOut && cntQ == '0)) else $error("timeout missed"); // R5
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (preBit && preQ != PRE_MAX && !fire && !strb.refreshOk) |=> $stable(cntQ)) else $error("prescale leak"); // R6
  AST_TOUT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.toutWe |=> $stable(toutQ)) else $error("timeout changed while closed"); // R8
endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import wdg_pkg::*;
#(
  parameter int          KEY_DEADLINE = 16,
  parameter int          RST_CYCLES   = 4,
  parameter int          PRE_LOG2     = 8,
  parameter logic [15:0] TOUT_INIT    = 16'h0100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntTick,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [15:0] wrData,
  output logic        wdgRst
);
  wdg_strobe_t strb;
  logic        earlyZone;

  wdg_control #(.KEY_DEADLINE(KEY_DEADLINE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .earlyZone(earlyZone), .strb(strb)
  );

  wdg_datapath #(.RST_CYCLES(RST_CYCLES), .PRE_LOG2(PRE_LOG2), .TOUT_INIT(TOUT_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrData(wrData), .strb(strb),
    .earlyZone(earlyZone), .rstOut(wdgRst)
  );
endmodule

// File: tb/sim_keyed_window_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_window_watchdog;
  localparam int DL = 16;
  localparam int RL = 4;

  logic        clk = 1'b0, rstN = 1'b0, cntTick = 1'b0, wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        wdgRst;

  keyed_window_watchdog u0 (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wdgRst(wdgRst)
  );

  always #2 clk = ~clk;

  int    total = 0, bad = 0, rises = 0, hiRun = 0, lastRun = 0, cycles = 0;
  bit    prevRst = 1'b0, done = 1'b0;
  string phase = "R1";

  // reference model state
  bit       mOpen, mRst, early, hit, ok, badr;
  logic [4:0] mCfg;
  int       mTout, mWin, mCnt, mPre, mPulse, mSeq, mAge;

  always @(posedge clk) begin
    if (!rstN) begin
      mOpen = 1; mCfg = 5'd1; mTout = 'h100; mWin = 0; mCnt = 0;
      mPre = 0; mPulse = 0; mSeq = 0; mAge = 0;
    end else begin
      early = mCfg[1] && (mCnt < mWin);
      case (mCfg[4:3])
        2'b01:   hit = (mCnt % 256) == (mTout % 256);
        2'b10:   hit = (mCnt / 256) == (mTout / 256);
        default: hit = (mCnt == mTout);
      endcase
      hit = hit && mCfg[0];
      ok = 0; badr = 0;
      if (wrEn && wrAddr == 2'd0) begin
        if (mSeq == 1) begin
          if (wrData == 16'h80B4 && !early) ok = 1; else badr = 1;
          mSeq = 0;
        end else if (mSeq == 2) begin
          if (wrData == 16'h28D9) mOpen = 1;
          mSeq = 0;
        end else if (wrData == 16'h02A6) begin mSeq = 1; mAge = 0; end
        else if (wrData == 16'h20C5) begin mSeq = 2; mAge = 0; end
      end else if (mSeq != 0) begin
        mAge++;
        if (mAge >= DL) mSeq = 0;
      end
      if (hit || badr || ok) begin
        mCnt = 0; mPre = 0;
      end else if (mCfg[0] && cntTick) begin
        if (mCfg[2]) begin
          if (mPre == 255) begin mPre = 0; mCnt = (mCnt + 1) % 65536; end
          else mPre++;
        end else mCnt = (mCnt + 1) % 65536;
      end
      if (hit || badr) mPulse = RL;
      else if (mPulse > 0) mPulse--;
      if (wrEn && mOpen) begin
        case (wrAddr)
          2'd1: begin mCfg = wrData[4:0]; mOpen = 0; end
          2'd2: mTout = wrData;
          2'd3: mWin = wrData;
          default: ;
        endcase
      end
    end
    mRst = (mPulse > 0);
  end

  always @(negedge clk) begin
    cycles++;
    total++;
    if (wdgRst !== mRst) begin
      bad++;
      $display("FAIL %s: wdgRst actual=%0b expected=%0b at %0t", phase, wdgRst, mRst, $time);
    end
    if (wdgRst && !prevRst) rises++;
    if (wdgRst) hiRun++;
    else if (prevRst) begin lastRun = hiRun; hiRun = 0; end
    prevRst = wdgRst;
    if (cycles > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung actual=%0d expected<=%0d cycles", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit cond, string req, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); wrEn = 1'b0; end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic keyPair(logic [15:0] k1, logic [15:0] k2, int gap);
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = k1;
    repeat (gap - 1) begin @(negedge clk); wrEn = 1'b0; end
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = k2;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); #1 rstN = 1'b0; cntTick = 1'b0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    phase = "R1";
    @(negedge clk);
    chk(wdgRst == 1'b0, "R1", wdgRst, 0);
    cntTick = 1'b1;

    phase = "R5"; rises = 0;
    idle(270);
    chk(rises == 1, "R5", rises, 1);
    chk(lastRun == RL, "R5 pulse length", lastRun, RL);

    phase = "R2"; rises = 0;
    for (int i = 0; i < 4; i++) begin
      idle(100);
      keyPair(16'h02A6, 16'h80B4, 16);
    end
    chk(rises == 0, "R2", rises, 0);

    phase = "R3"; rises = 0;
    idle(200);
    keyPair(16'h02A6, 16'h80B4, 17);
    idle(80);
    chk(rises == 1, "R3", rises, 1);

    phase = "R4"; rises = 0;
    idle(10);
    keyPair(16'h02A6, 16'h1234, 3);
    idle(6);
    chk(rises == 1, "R4", rises, 1);

    phase = "R8"; rises = 0;
    wr(2'd2, 16'h00C0);
    wr(2'd3, 16'h0040);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0050);
    wr(2'd3, 16'h0000);
    idle(100);
    keyPair(16'h02A6, 16'h80B4, 4);
    idle(10);
    chk(rises == 0, "R8", rises, 0);

    phase = "R7"; rises = 0;
    keyPair(16'h02A6, 16'h80B4, 3);
    idle(5);
    chk(rises == 1, "R7", rises, 1);

    phase = "R9"; rises = 0;
    keyPair(16'h20C5, 16'h1111, 2);
    wr(2'd2, 16'h0014);
    idle(40);
    chk(rises == 0, "R9", rises, 0);

    phase = "R10"; rises = 0;
    keyPair(16'h20C5, 16'h28D9, 16);
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h1203);
    wr(2'd1, 16'h0009);
    idle(300);
    chk(rises == 1, "R10 low byte", rises, 1);

    doReset();
    phase = "R10"; rises = 0;
    wr(2'd2, 16'h01FF);
    wr(2'd1, 16'h0011);
    cntTick = 1'b1;
    idle(200);
    chk(rises == 0, "R10 high byte early", rises, 0);
    idle(100);
    chk(rises == 1, "R10 high byte", rises, 1);

    doReset();
    phase = "R6"; rises = 0;
    wr(2'd2, 16'h0002);
    wr(2'd1, 16'h0005);
    cntTick = 1'b1;
    idle(400);
    chk(rises == 0, "R6 before", rises, 0);
    idle(200);
    chk(rises == 1, "R6 after", rises, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule